// File: doc/BRIEF.md
# Fractional Multiply-Accumulate-Round Unit

This unit performs one signed fractional multiply-accumulate followed by a rounding step, against a 40-bit accumulator. The accumulator is made of an 8-bit extension, a 16-bit high half and a 16-bit low half. For each issued operation, the unit takes the upper 16 bits of two source words and treats them as signed Q15 fractions. It doubles their product to form a Q31 value and adds that value to the destination accumulator, or subtracts it. It then rounds the sum into the high half and clears the bits below the rounding point.

Three control inputs set how the result is shaped. The first picks convergent or two's-complement rounding. The second is a scaling mode, which moves the rounding position and the window used to compute the limit bit. The third enables 32-bit saturation, which clips out-of-range results and forces the limit bit low. Results are registered and appear one cycle after issue. A sticky overflow flag records every 40-bit overflow and every saturation clip since reset. Decode, register storage and memory access are handled outside the unit.

Top module: `fmac_round_unit`

## Requirements
- R1: While rst_ni is low and after it rises, valid_o, acc_o, limit_o and ovf_o are all zero until the first issued operation.
- R2: On a cycle with valid_i high, the next cycle shows valid_o high and acc_o equal to the rounded value of acc_i plus (sub_i=0) or minus (sub_i=1) twice the signed product of src_a_i[31:16] and src_b_i[31:16], sign-extended to 40 bits. Bits 15:0 of both sources have no effect.
- R3: When both source high halves are 0x8000, the doubled product is taken as +0x7FFF_FFFF.
- R4: With rnd_twos_i=0 and scale_i=00 (or the reserved value 11), the unit adds 0x8000 to the sum. If the sum's bits 15:0 are exactly 0x8000, bit 16 of the result is forced to 0. Bits 15:0 of acc_o are always zero. Example: acc 0x00_0007_0000 with both high halves 0x0080 gives 0x00_0008_0000.
- R5: With rnd_twos_i=1, the half constant is always added and there is no tie correction. Example: 0x00_0008_8000 becomes 0x00_0009_0000.
- R6: scale_i=01 (scale down) rounds at bit 17. It adds 0x1_0000, resolves a tie on bits 16:0 by clearing bit 17, and zeroes bits 16:0. scale_i=10 (scale up) adds 0x4000 and zeroes bits 15:0.
- R7: With sat_en_i=0, limit_o is 1 exactly when the 40-bit result's bits 39:31 (scale 00/11), 39:32 (scale 01) or 39:30 (scale 10) are not all equal.
- R8: With sat_en_i=1, limit_o is 0. A result outside 32 bits, meaning bits 39:31 are not all equal or the sum overflowed 40 bits, is clipped by its true sign to 0x00_7FFF_0000 or 0xFF_8000_0000.
- R9: ovf_o goes high after an issued operation whose rounded sum does not fit in 40 bits, or which was clipped by saturation. It then stays high until reset.
- R10: On a cycle with valid_i low, valid_o goes low next cycle, and acc_o and limit_o keep their previous values whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Issue an operation this cycle |
| src_a_i | input | 32 | First source word; bits 31:16 used |
| src_b_i | input | 32 | Second source word; bits 31:16 used |
| acc_i | input | 40 | Destination accumulator value |
| sub_i | input | 1 | 1 subtracts the product, 0 adds it |
| rnd_twos_i | input | 1 | 1 two's-complement rounding, 0 convergent |
| sat_en_i | input | 1 | Enable 32-bit saturation |
| scale_i | input | 2 | 00 none, 01 down, 10 up, 11 none |
| valid_o | output | 1 | Result valid |
| acc_o | output | 40 | Rounded accumulator result |
| limit_o | output | 1 | Limit bit of the result |
| ovf_o | output | 1 | Sticky overflow flag |

## Verification
Several properties are checked by assertions on every cycle. The low half of every valid result is zero. Saturation mode always leaves limit_o low and the result inside 32 bits. The overflow flag never falls while out of reset. Idle cycles leave the result untouched. A further assertion confirms that the most-negative operand pair gives the clamped maximum product. Exact arithmetic values are shown only by the bench's scenarios. These cover tie handling in each rounding mode and scale, the limit window for each scale, the sign used when a 40-bit overflow is clipped, and the independence from the source low halves. The bench checks them with its behavioural reference model over directed and random operations.

// File: rtl/fmac_pkg.sv
package fmac_pkg;
  typedef enum logic [1:0] {
    SCL_NONE = 2'b00,
    SCL_DOWN = 2'b01,
    SCL_UP   = 2'b10,
    SCL_RSVD = 2'b11
  } scale_e;
endpackage

// File: rtl/fmac_mult.sv
module fmac_mult #(
  parameter int HALF_W = 16
) (
  input  logic [HALF_W-1:0]   op_a_i,
  input  logic [HALF_W-1:0]   op_b_i,
  output logic [2*HALF_W-1:0] frac_o
);
  localparam int PW = 2 * HALF_W;
  localparam logic [HALF_W-1:0] MIN_H = {1'b1, {(HALF_W-1){1'b0}}};

  logic signed [PW-1:0] prod;
  logic                 both_min;

  assign prod     = $signed(op_a_i) * $signed(op_b_i);
  assign both_min = (op_a_i == MIN_H) && (op_b_i == MIN_H);
  // -1.0 * -1.0 does not fit Q31: clamp to max positive
  assign frac_o   = both_min ? {1'b0, {(PW-1){1'b1}}} : (prod <<< 1);
endmodule

// File: rtl/fmac_round.sv
module fmac_round
  import fmac_pkg::*;
#(
  parameter int ACC_W  = 40,
  parameter int HALF_W = 16
) (
  input  logic [ACC_W-1:0]    acc_i,
  input  logic [2*HALF_W-1:0] frac_i,
  input  logic                sub_i,
  input  logic                twos_i,
  input  logic                sat_i,
  input  scale_e              scale_i,
  output logic [ACC_W-1:0]    res_o,
  output logic                limit_o,
  output logic                ovf_o
);
  localparam int PW    = 2 * HALF_W;
  localparam int EXT_W = ACC_W - PW;
  localparam int WW    = ACC_W + 2;
  localparam logic [ACC_W-1:0] POS_MAX = {{(EXT_W+1){1'b0}}, {(HALF_W-1){1'b1}}, {HALF_W{1'b0}}};
  localparam logic [ACC_W-1:0] NEG_MAX = {{(EXT_W+1){1'b1}}, {(PW-1){1'b0}}};
  localparam logic [WW-1:0]    ONE     = {{(WW-1){1'b0}}, 1'b1};

  logic [WW-1:0]    acc_x, frac_x, sum, full, rc, low_mask;
  logic [ACC_W-1:0] rnd, clr_mask;
  logic [5:0]       rpos, clr_w;
  logic             tie, ovf40, fit_none, fit_down, fit_up, lim, clip;

  assign acc_x  = {{2{acc_i[ACC_W-1]}}, acc_i};
  assign frac_x = {{(WW-PW){frac_i[PW-1]}}, frac_i};
  assign sum    = sub_i ? (acc_x - frac_x) : (acc_x + frac_x);

  always_comb begin
    unique case (scale_i)
      SCL_DOWN: rpos = 6'(HALF_W + 1);
      SCL_UP:   rpos = 6'(HALF_W - 1);
      default:  rpos = 6'(HALF_W);
    endcase
    clr_w = (rpos > 6'(HALF_W)) ? rpos : 6'(HALF_W);
  end

  assign rc       = ONE << (rpos - 6'd1);
  assign low_mask = (ONE << rpos) - ONE;
  assign tie      = (sum & low_mask) == rc;
  assign full     = sum + rc;
  assign ovf40    = !((&full[WW-1:ACC_W-1]) || !(|full[WW-1:ACC_W-1]));
  assign clr_mask = ACC_W'((ONE << clr_w) - ONE);

  always_comb begin
    rnd = full[ACC_W-1:0];
    if (!twos_i && tie) rnd[rpos] = 1'b0;
    rnd = rnd & ~clr_mask;
  end

  assign fit_none = (&rnd[ACC_W-1:PW-1]) || !(|rnd[ACC_W-1:PW-1]);
  assign fit_down = (&rnd[ACC_W-1:PW])   || !(|rnd[ACC_W-1:PW]);
  assign fit_up   = (&rnd[ACC_W-1:PW-2]) || !(|rnd[ACC_W-1:PW-2]);

  always_comb begin
    unique case (scale_i)
      SCL_DOWN: lim = !fit_down;
      SCL_UP:   lim = !fit_up;
      default:  lim = !fit_none;
    endcase
  end

  assign clip    = sat_i && (ovf40 || !fit_none);
  assign res_o   = clip ? (full[WW-1] ? NEG_MAX : POS_MAX) : rnd;
  assign limit_o = sat_i ? 1'b0 : lim;
  assign ovf_o   = ovf40 || clip;
endmodule

// File: rtl/fmac_round_unit.sv
module fmac_round_unit
  import fmac_pkg::*;
#(
  parameter int HALF_W = 16,
  parameter int EXT_W  = 8,
  localparam int DW    = 2 * HALF_W,
  localparam int ACC_W = DW + EXT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [DW-1:0]    src_a_i,
  input  logic [DW-1:0]    src_b_i,
  input  logic [ACC_W-1:0] acc_i,
  input  logic             sub_i,
  input  logic             rnd_twos_i,
  input  logic             sat_en_i,
  input  logic [1:0]       scale_i,
  output logic             valid_o,
  output logic [ACC_W-1:0] acc_o,
  output logic             limit_o,
  output logic             ovf_o
);
  logic [DW-1:0]    frac;
  logic [ACC_W-1:0] res;
  logic             lim, ovf_ev, unused_low;

  assign unused_low = ^{src_a_i[HALF_W-1:0], src_b_i[HALF_W-1:0]};

  fmac_mult #(.HALF_W(HALF_W)) u_mult (
    .op_a_i (src_a_i[DW-1:HALF_W]),
    .op_b_i (src_b_i[DW-1:HALF_W]),
    .frac_o (frac)
  );

  fmac_round #(.ACC_W(ACC_W), .HALF_W(HALF_W)) u_round (
    .acc_i   (acc_i),
    .frac_i  (frac),
    .sub_i   (sub_i),
    .twos_i  (rnd_twos_i),
    .sat_i   (sat_en_i),
    .scale_i (scale_e'(scale_i)),
    .res_o   (res),
    .limit_o (lim),
    .ovf_o   (ovf_ev)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      acc_o   <= '0;
      limit_o <= 1'b0;
      ovf_o   <= 1'b0;
    end else begin
      valid_o <= valid_i;
      ovf_o   <= ovf_o | (valid_i & ovf_ev);
      if (valid_i) begin
        acc_o   <= res;
        limit_o <= lim;
      end
    end
  end

  // R3
  min_prod_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_a_i[DW-1:HALF_W] == {1'b1, {(HALF_W-1){1'b0}}} &&
     src_b_i[DW-1:HALF_W] == {1'b1, {(HALF_W-1){1'b0}}})
    |-> frac == {1'b0, {(DW-1){1'b1}}});

  // R4
  low_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> acc_o[HALF_W-1:0] == '0);

  // R8
  sat_lim_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && sat_en_i) |=> !limit_o);

  // R8
  sat_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && sat_en_i) |=> ((&acc_o[ACC_W-1:DW-1]) || !(|acc_o[ACC_W-1:DW-1])));

  // R9
  ovf_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |=> ovf_o);

  // R10
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(acc_o) && $stable(limit_o) && !valid_o));
endmodule

// File: tb/fmac_round_unit_bench.sv
module fmac_round_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_i = 1'b0;
  logic [31:0] src_a_i = '0, src_b_i = '0;
  logic [39:0] acc_i = '0;
  logic        sub_i = 1'b0, rnd_twos_i = 1'b0, sat_en_i = 1'b0;
  logic [1:0]  scale_i = 2'b00;
  logic        valid_o, limit_o, ovf_o;
  logic [39:0] acc_o;

  int    n_cmp = 0, n_bad = 0;
  bit    done = 0;
  string cur_tag = "R1", exp_tag = "R1";
  bit          e_vld = 0, e_lim = 0, e_ovf = 0;
  logic [39:0] e_acc = '0;

  always #5 clk = ~clk;

  fmac_round_unit u_fmac_round_unit (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .src_a_i(src_a_i), .src_b_i(src_b_i),
    .acc_i(acc_i), .sub_i(sub_i), .rnd_twos_i(rnd_twos_i), .sat_en_i(sat_en_i),
    .scale_i(scale_i), .valid_o(valid_o), .acc_o(acc_o), .limit_o(limit_o), .ovf_o(ovf_o)
  );

  // behavioural reference, updated at each rising edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e_vld = 0; e_lim = 0; e_ovf = 0; e_acc = '0; exp_tag = "R1";
    end else begin
      e_vld   = valid_i;
      exp_tag = cur_tag;
      if (valid_i) begin
        longint pa, pb, prod, frac, av, sum, rc, full, res, r, bound;
        int rpos, clrb;
        bit tie, ovf40, clip, lim;
        pa   = longint'($signed(src_a_i[31:16]));
        pb   = longint'($signed(src_b_i[31:16]));
        prod = pa * pb;
        frac = (prod == 64'sh4000_0000) ? 64'sh7FFF_FFFF : prod * 2;
        av   = longint'($signed(acc_i));
        sum  = sub_i ? av - frac : av + frac;
        rpos = (scale_i == 2'b01) ? 17 : (scale_i == 2'b10) ? 15 : 16;
        rc   = longint'(1) << (rpos - 1);
        tie  = (sum & ((longint'(1) << rpos) - 1)) == rc;
        full = sum + rc;
        ovf40 = (full > 64'sh7F_FFFF_FFFF) || (full < -64'sh80_0000_0000);
        res  = full & 64'hFF_FFFF_FFFF;
        if (!rnd_twos_i && tie) res = res & ~(longint'(1) << rpos);
        clrb = (rpos > 16) ? rpos : 16;
        res  = res & ~((longint'(1) << clrb) - 1);
        r    = (res ^ (longint'(1) << 39)) - (longint'(1) << 39);
        bound = (scale_i == 2'b01) ? 64'sh1_0000_0000 :
                (scale_i == 2'b10) ? 64'sh4000_0000 : 64'sh8000_0000;
        lim  = (r >= bound) || (r < -bound);
        clip = sat_en_i && (ovf40 || r >= 64'sh8000_0000 || r < -64'sh8000_0000);
        if (clip) res = (full < 0) ? 64'hFF_8000_0000 : 64'h00_7FFF_0000;
        if (sat_en_i) lim = 0;
        e_acc = res[39:0];
        e_lim = lim;
        e_ovf = e_ovf | ovf40 | clip;
      end
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      n_cmp++;
      if (valid_o !== e_vld || acc_o !== e_acc || limit_o !== e_lim || ovf_o !== e_ovf) begin
        n_bad++;
        $display("FAIL %s: got vld=%0b acc=%010h lim=%0b ovf=%0b exp vld=%0b acc=%010h lim=%0b ovf=%0b",
                 exp_tag, valid_o, acc_o, limit_o, ovf_o, e_vld, e_acc, e_lim, e_ovf);
      end
    end
  end

  task automatic op(input string tag, input logic [31:0] a, input logic [31:0] b,
                    input logic [39:0] acc, input bit sub, input bit twos,
                    input bit sat, input logic [1:0] scl);
    @(posedge clk); #2;
    cur_tag = tag; valid_i = 1'b1; src_a_i = a; src_b_i = b; acc_i = acc;
    sub_i = sub; rnd_twos_i = twos; sat_en_i = sat; scale_i = scl;
  endtask

  task automatic idle(input string tag);
    @(posedge clk); #2;
    cur_tag = tag; valid_i = 1'b0;
    src_a_i = $urandom; src_b_i = $urandom; acc_i = {8'($urandom), 32'($urandom)};
    sub_i = 1'($urandom); sat_en_i = 1'($urandom); scale_i = 2'($urandom);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog: got timeout exp completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    repeat (2) @(posedge clk);
    // R4 worked case; R2 low halves differ
    op("R4", 32'h0080_1234, 32'h0080_FFFF, 40'h00_0007_0000, 0, 0, 0, 2'b00);
    op("R4", 32'h0080_0000, 32'h0080_0000, 40'h00_0008_0000, 0, 0, 0, 2'b00);
    op("R5", 32'h0080_0000, 32'h0080_0000, 40'h00_0008_0000, 0, 1, 0, 2'b00);
    op("R4", 32'h0080_0000, 32'h0080_0000, 40'h00_0008_0000, 0, 0, 0, 2'b11);
    op("R2", 32'h4000_5555, 32'h4000_AAAA, 40'h00_4000_0000, 1, 0, 0, 2'b00);
    op("R2", 32'hC000_0000, 32'h2000_0000, 40'hFF_F000_1234, 0, 0, 0, 2'b00);
    op("R3", 32'h8000_0000, 32'h8000_0001, 40'h00_0000_0000, 0, 0, 0, 2'b00);
    op("R6", 32'h0, 32'h0, 40'h00_0003_0000, 0, 0, 0, 2'b01);
    op("R6", 32'h0, 32'h0, 40'h00_0001_0000, 0, 0, 0, 2'b01);
    op("R6", 32'h0, 32'h0, 40'h00_0001_0000, 0, 1, 0, 2'b01);
    op("R6", 32'h0, 32'h0, 40'h00_0001_4000, 0, 0, 0, 2'b10);
    op("R6", 32'h0, 32'h0, 40'h00_0001_C000, 0, 0, 0, 2'b10);
    op("R7", 32'h0, 32'h0, 40'h00_8000_0000, 0, 0, 0, 2'b01);
    op("R7", 32'h0, 32'h0, 40'h00_8000_0000, 0, 0, 0, 2'b00);
    op("R7", 32'h0, 32'h0, 40'h00_4000_0000, 0, 0, 0, 2'b10);
    op("R7", 32'h0, 32'h0, 40'hFF_8000_0000, 0, 0, 0, 2'b00);
    op("R10", 32'h0100_0000, 32'h0100_0000, 40'h00_1234_0000, 0, 0, 0, 2'b00);
    for (int i = 0; i < 4; i++) idle("R10");
    // sweep of mixed operations; saturation off
    for (int i = 0; i < 300; i++)
      op("R2", $urandom, $urandom, {8'($urandom) & 8'h01 ? 8'h00 : 8'hFF, 32'($urandom)},
         1'($urandom), 1'($urandom), 0, 2'($urandom));
    // R8 clipping, positive and negative
    op("R8", 32'h8000_0000, 32'h8000_0000, 40'h00_0000_0000, 0, 0, 1, 2'b00);
    op("R8", 32'h0, 32'h0, 40'h00_7FFF_8000, 0, 0, 1, 2'b00);
    op("R8", 32'h7FFF_0000, 32'h7FFF_0000, 40'hFF_8000_0000, 1, 0, 1, 2'b00);
    op("R8", 32'h0, 32'h0, 40'h00_1234_5678, 0, 0, 1, 2'b10);
    // R9 sticky after clip, then 40-bit overflow with true sign under saturation
    op("R9", 32'h0, 32'h0, 40'h00_0001_0000, 0, 0, 0, 2'b00);
    op("R9", 32'h7FFF_0000, 32'h7FFF_0000, 40'h7F_FFFF_0000, 0, 0, 1, 2'b00);
    op("R8", 32'h8000_0000, 32'h7FFF_0000, 40'h80_0000_0000, 0, 0, 1, 2'b00);
    for (int i = 0; i < 300; i++)
      op("R8", $urandom, $urandom, {8'($urandom), 32'($urandom)},
         1'($urandom), 1'($urandom), 1'($urandom), 2'($urandom));
    idle("R10");
    repeat (3) @(posedge clk);
    // R1 re-entry to reset clears everything
    #2 rst_n = 1'b0;
    repeat (2) @(posedge clk);
    #2 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    done = 1;
    summary();
    $finish;
  end
endmodule